// File: doc/BRIEF.md
# Serial Configuration Port with Addressed Holding Registers

This block is the configuration front end of a frequency synthesizer. Software or a board controller drives three slow pins: a serial clock, a serial data line and a latch line. Data bits are shifted into a fixed-length word, most significant bit first. On a rising edge of the latch line, the low address bits of that word pick one holding register, and the payload bits above the address are copied into it. The holding registers feed parallel configuration buses for the RF and IF divider chains, along with one run/power-save bit for the RF section.

All three pins are sampled by the system clock. Each pin passes through a multi-stage synchronizer, and edges are detected after synchronization, so no logic runs on the serial clock itself. Each divider group has its own register. When a divider group takes new contents, the block raises a one-cycle load strobe toward that divider. A word whose address selects no register is thrown away.

Top module: `serial_cfg_port`

## Requirements
- R1: After a synchronous active-low reset, every divider field reads zero, `rf_run` is 0 (RF section in power save) and `div_load` is 0.
- R2: The word is 22 bits long. Each rising edge of `ser_clk` shifts one bit of `ser_dat` into it, most significant bit first, so the last three bits sent form the address field at bits [2:0].
- R3: Shifting alone changes no output. Holding registers update only on a rising edge of `ser_latch`.
- R4: Address 0 loads `rf_run` from word bit 3. A 0 selects power save and a 1 selects run. No other address changes `rf_run`.
- R5: Address 1 loads `rf_ref_div` from word bits [15:3].
- R6: Address 2 loads `rf_int_div` from bits [15:3] and `rf_swallow` from bits [21:16].
- R7: Address 3 loads `rf_frac_num` from bits [5:3].
- R8: Address 4 loads `if_ref_div` from bits [17:3].
- R9: Address 5 loads `if_int_div` from bits [15:3] and `if_swallow` from bits [19:16].
- R10: Addresses 6 and 7 are discarded. No output changes and no strobe is raised.
- R11: The update at addresses 1 to 5 comes with a one-cycle pulse on exactly one `div_load` bit, in the same cycle the outputs change. The bits are: bit 0 for address 1, bit 1 for address 2, bit 2 for address 3, bit 3 for address 4 and bit 4 for address 5. Address 0 raises no strobe.
- R12: While `ser_latch` stays high, further shifting loads nothing. Only the next low-to-high transition loads.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ser_clk | input | 1 | Serial shift clock (asynchronous) |
| ser_dat | input | 1 | Serial data, MSB first (asynchronous) |
| ser_latch | input | 1 | Latch line; rising edge loads the addressed register |
| rf_run | output | 1 | RF section run (1) or power save (0) |
| rf_ref_div | output | 13 | RF reference divider value |
| rf_int_div | output | 13 | RF main counter value |
| rf_swallow | output | 6 | RF swallow counter value |
| rf_frac_num | output | 3 | RF fractional numerator |
| if_ref_div | output | 15 | IF reference divider value |
| if_int_div | output | 13 | IF main counter value |
| if_swallow | output | 4 | IF swallow counter value |
| div_load | output | 5 | One-cycle load strobes, one per divider group |

## Verification
The assertions assume the serial pins are slow compared with the system clock. Each level must hold for several system cycles, so a synchronized edge never repeats in adjacent cycles and two strobes are never back to back. They also assume `ser_dat` is stable around each serial clock edge and that no serial clock edge arrives in the same cycle as a latch edge. The bench holds every pin level for at least four system cycles, changes data only while the serial clock is low, and separates the latch pulse from the shifting. It then sweeps all eight addresses with several payload patterns and compares every output against fields extracted arithmetically from the sent word.

// File: rtl/serial_cfg_pkg.sv
// Package: shared widths, address codes and the configuration record
// for the serial configuration port.
package serial_cfg_pkg;
    parameter int ADDR_W = 3;
    parameter int RF_R_W = 13;
    parameter int RF_P_W = 13;
    parameter int RF_S_W = 6;
    parameter int RF_M_W = 3;
    parameter int IF_R_W = 15;
    parameter int IF_A_W = 13;
    parameter int IF_B_W = 4;
    parameter int N_LOAD = 5;
    // Longest payload: RF main counter plus swallow above the address.
    parameter int WORD_W = ADDR_W + RF_P_W + RF_S_W;

    localparam logic [ADDR_W-1:0] ADR_PWR     = 3'd0;
    localparam logic [ADDR_W-1:0] ADR_RF_REF  = 3'd1;
    localparam logic [ADDR_W-1:0] ADR_RF_MAIN = 3'd2;
    localparam logic [ADDR_W-1:0] ADR_RF_FRAC = 3'd3;
    localparam logic [ADDR_W-1:0] ADR_IF_REF  = 3'd4;
    localparam logic [ADDR_W-1:0] ADR_IF_MAIN = 3'd5;

    localparam int LD_RF_REF  = 0;
    localparam int LD_RF_MAIN = 1;
    localparam int LD_RF_FRAC = 2;
    localparam int LD_IF_REF  = 3;
    localparam int LD_IF_MAIN = 4;

    typedef struct packed {
        logic              run;
        logic [RF_R_W-1:0] rf_ref;
        logic [RF_P_W-1:0] rf_int;
        logic [RF_S_W-1:0] rf_swl;
        logic [RF_M_W-1:0] rf_num;
        logic [IF_R_W-1:0] if_ref;
        logic [IF_A_W-1:0] if_int;
        logic [IF_B_W-1:0] if_swl;
    } cfg_t;
endpackage

// File: rtl/scp_pin_sync.sv
// Module: scp_pin_sync
// Brings WIDTH asynchronous pins into the clk domain through STAGES
// flops each, then gives the synchronized level and a one-cycle rise
// pulse per pin. Assumes STAGES >= 2 and pin levels that last several
// clk cycles.
module scp_pin_sync #(
    parameter int WIDTH  = 3,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] pin_in,
    output logic [WIDTH-1:0] lvl,
    output logic [WIDTH-1:0] rise
);
    logic [WIDTH-1:0][STAGES-1:0] chain;
    logic [WIDTH-1:0]             prev;

    for (genvar i = 0; i < WIDTH; i++) begin : g_pin
        // Purpose: shift the pin through the synchronizer chain.
        always_ff @(posedge clk) begin
            if (!rst_n) chain[i] <= '0;
            else        chain[i] <= {chain[i][STAGES-2:0], pin_in[i]};
        end
        assign lvl[i] = chain[i][STAGES-1];
    end

    // Purpose: remember the previous synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) prev <= '0;
        else        prev <= lvl;
    end

    assign rise = lvl & ~prev;

    AST_RISE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((rise & $past(rise)) == '0)); // R2
endmodule

// File: rtl/scp_shifter.sv
// Module: scp_shifter
// Serial-in word register. On each synchronized serial clock rise it
// shifts left and takes the synchronized data bit into bit 0, so the
// first bit sent ends at the MSB. Assumes data is stable at the edge.
module scp_shifter #(
    parameter int WORD_W = 22
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              shift_en,
    input  logic              din,
    output logic [WORD_W-1:0] word
);
    // Purpose: shift one bit per enabled cycle, MSB first.
    always_ff @(posedge clk) begin
        if (!rst_n)        word <= '0;
        else if (shift_en) word <= {word[WORD_W-2:0], din};
    end

    AST_SHIFT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !shift_en |=> $stable(word)); // R2
    AST_SHIFT_MOVE: assert property (@(posedge clk) disable iff (!rst_n)
        shift_en |=> (word[WORD_W-1:1] == $past(word[WORD_W-2:0]))); // R2
endmodule

// File: rtl/scp_reg_bank.sv
// Module: scp_reg_bank
// Holding registers. On a latch rise it decodes the address field of
// the shifted word, loads the chosen register from the payload, and
// raises the matching one-cycle load strobe. Unknown addresses are
// dropped. Assumes latch rises are several cycles apart.
module scp_reg_bank
    import serial_cfg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              latch_rise,
    input  logic [WORD_W-1:0] word,
    output cfg_t              cfg_q,
    output logic [N_LOAD-1:0] load_q
);
    logic [ADDR_W-1:0] adr;
    cfg_t              cfg_d;
    logic [N_LOAD-1:0] load_d;

    assign adr = word[ADDR_W-1:0];

    // Purpose: work out the next register contents and strobe.
    always_comb begin
        cfg_d  = cfg_q;
        load_d = '0;
        if (latch_rise) begin
            case (adr)
                ADR_PWR: cfg_d.run = word[ADDR_W];
                ADR_RF_REF: begin
                    cfg_d.rf_ref      = word[ADDR_W +: RF_R_W];
                    load_d[LD_RF_REF] = 1'b1;
                end
                ADR_RF_MAIN: begin
                    cfg_d.rf_int       = word[ADDR_W +: RF_P_W];
                    cfg_d.rf_swl       = word[ADDR_W + RF_P_W +: RF_S_W];
                    load_d[LD_RF_MAIN] = 1'b1;
                end
                ADR_RF_FRAC: begin
                    cfg_d.rf_num       = word[ADDR_W +: RF_M_W];
                    load_d[LD_RF_FRAC] = 1'b1;
                end
                ADR_IF_REF: begin
                    cfg_d.if_ref      = word[ADDR_W +: IF_R_W];
                    load_d[LD_IF_REF] = 1'b1;
                end
                ADR_IF_MAIN: begin
                    cfg_d.if_int       = word[ADDR_W +: IF_A_W];
                    cfg_d.if_swl       = word[ADDR_W + IF_A_W +: IF_B_W];
                    load_d[LD_IF_MAIN] = 1'b1;
                end
                default: ;
            endcase
        end
    end

    // Purpose: hold the registers and strobe; reset to zero and power save.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_q  <= '0;
            load_q <= '0;
        end else begin
            cfg_q  <= cfg_d;
            load_q <= load_d;
        end
    end

    AST_HOLD_NO_LATCH: assert property (@(posedge clk) disable iff (!rst_n)
        !latch_rise |=> ($stable(cfg_q) && load_q == '0)); // R3
    AST_UNUSED_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
        (latch_rise && adr > ADR_IF_MAIN) |=> ($stable(cfg_q) && load_q == '0)); // R10
    AST_RUN_ONLY_ADDR0: assert property (@(posedge clk) disable iff (!rst_n)
        !(latch_rise && adr == ADR_PWR) |=> $stable(cfg_q.run)); // R4
    AST_STROBE_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(load_q)); // R11
    AST_STROBE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        (load_q != '0) |=> (load_q == '0)); // R11
endmodule

// File: rtl/serial_cfg_port.sv
// Module: serial_cfg_port (top)
// Three-pin serial configuration port. It synchronizes the pins,
// shifts a fixed-length word MSB first, and latches it on the latch
// line rise into the addressed holding register. Assumes pin levels
// last several clk cycles.
module serial_cfg_port
    import serial_cfg_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ser_clk,
    input  logic              ser_dat,
    input  logic              ser_latch,
    output logic              rf_run,
    output logic [RF_R_W-1:0] rf_ref_div,
    output logic [RF_P_W-1:0] rf_int_div,
    output logic [RF_S_W-1:0] rf_swallow,
    output logic [RF_M_W-1:0] rf_frac_num,
    output logic [IF_R_W-1:0] if_ref_div,
    output logic [IF_A_W-1:0] if_int_div,
    output logic [IF_B_W-1:0] if_swallow,
    output logic [N_LOAD-1:0] div_load
);
    localparam int N_PIN = 3;
    localparam int P_CLK = 0;
    localparam int P_DAT = 1;
    localparam int P_LAT = 2;

    logic [N_PIN-1:0]  pin_lvl;
    logic [N_PIN-1:0]  pin_rise;
    logic [WORD_W-1:0] word;
    cfg_t              cfg;

    scp_pin_sync #(.WIDTH(N_PIN), .STAGES(SYNC_STAGES)) i_sync (
        .clk    (clk),
        .rst_n  (rst_n),
        .pin_in ({ser_latch, ser_dat, ser_clk}),
        .lvl    (pin_lvl),
        .rise   (pin_rise)
    );

    scp_shifter #(.WORD_W(WORD_W)) i_shift (
        .clk      (clk),
        .rst_n    (rst_n),
        .shift_en (pin_rise[P_CLK]),
        .din      (pin_lvl[P_DAT]),
        .word     (word)
    );

    scp_reg_bank i_bank (
        .clk        (clk),
        .rst_n      (rst_n),
        .latch_rise (pin_rise[P_LAT]),
        .word       (word),
        .cfg_q      (cfg),
        .load_q     (div_load)
    );

    assign rf_run      = cfg.run;
    assign rf_ref_div  = cfg.rf_ref;
    assign rf_int_div  = cfg.rf_int;
    assign rf_swallow  = cfg.rf_swl;
    assign rf_frac_num = cfg.rf_num;
    assign if_ref_div  = cfg.if_ref;
    assign if_int_div  = cfg.if_int;
    assign if_swallow  = cfg.if_swl;
endmodule

// File: tb/test_serial_cfg_port.sv
`timescale 1ns/1ps
module test_serial_cfg_port;
    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic ser_clk = 1'b0, ser_dat = 1'b0, ser_latch = 1'b0;
    logic        rf_run;
    logic [12:0] rf_ref_div, rf_int_div, if_int_div;
    logic [5:0]  rf_swallow;
    logic [2:0]  rf_frac_num;
    logic [14:0] if_ref_div;
    logic [3:0]  if_swallow;
    logic [4:0]  div_load;

    int n_chk = 0, n_fail = 0;
    bit done = 1'b0;
    int strobe_cnt = 0;
    logic [4:0] strobe_last = '0;

    // expected model
    logic        e_run = 1'b0;
    logic [12:0] e_rref = '0, e_rint = '0, e_iint = '0;
    logic [5:0]  e_rswl = '0;
    logic [2:0]  e_rnum = '0;
    logic [14:0] e_iref = '0;
    logic [3:0]  e_iswl = '0;

    always #10 clk = ~clk;

    serial_cfg_port i_serial_cfg_port (
        .clk(clk), .rst_n(rst_n), .ser_clk(ser_clk), .ser_dat(ser_dat),
        .ser_latch(ser_latch), .rf_run(rf_run), .rf_ref_div(rf_ref_div),
        .rf_int_div(rf_int_div), .rf_swallow(rf_swallow),
        .rf_frac_num(rf_frac_num), .if_ref_div(if_ref_div),
        .if_int_div(if_int_div), .if_swallow(if_swallow),
        .div_load(div_load)
    );

    // count strobe cycles away from the active edge
    always @(negedge clk) begin
        if (div_load != '0) begin
            strobe_cnt  <= strobe_cnt + 1;
            strobe_last <= div_load;
        end
    end

    task automatic chk(input string req, input longint act, input longint exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic check_all(input string tag);
        @(negedge clk);
        chk({"R4 rf_run ", tag}, rf_run, e_run);
        chk({"R5 rf_ref_div ", tag}, rf_ref_div, e_rref);
        chk({"R6 rf_int_div ", tag}, rf_int_div, e_rint);
        chk({"R6 rf_swallow ", tag}, rf_swallow, e_rswl);
        chk({"R7 rf_frac_num ", tag}, rf_frac_num, e_rnum);
        chk({"R8 if_ref_div ", tag}, if_ref_div, e_iref);
        chk({"R9 if_int_div ", tag}, if_int_div, e_iint);
        chk({"R9 if_swallow ", tag}, if_swallow, e_iswl);
    endtask

    // MSB first, data changed only while serial clock is low
    task automatic send_word(input logic [21:0] w);
        for (int i = 21; i >= 0; i--) begin
            ser_dat = w[i];
            repeat (4) @(posedge clk);
            ser_clk = 1'b1;
            repeat (4) @(posedge clk);
            ser_clk = 1'b0;
        end
        repeat (6) @(posedge clk);
    endtask

    task automatic latch_pulse();
        ser_latch = 1'b1;
        repeat (6) @(posedge clk);
        ser_latch = 1'b0;
        repeat (6) @(posedge clk);
    endtask

    // arithmetic model of the addressed load
    task automatic model_load(input logic [21:0] w);
        int a;
        a = int'(w % 8);
        case (a)
            0: e_run  = w[3];
            1: e_rref = 13'((w / 8) % 8192);
            2: begin
                e_rint = 13'((w / 8) % 8192);
                e_rswl = 6'((w / 65536) % 64);
            end
            3: e_rnum = 3'((w / 8) % 8);
            4: e_iref = 15'((w / 8) % 32768);
            5: begin
                e_iint = 13'((w / 8) % 8192);
                e_iswl = 4'((w / 65536) % 16);
            end
            default: ;
        endcase
    endtask

    function automatic logic [4:0] exp_strobe(input int a);
        if (a >= 1 && a <= 5) return 5'(1 << (a - 1));
        return 5'd0;
    endfunction

    function automatic logic [18:0] payload(input int k, input int a);
        case (k)
            0: return '1;
            1: return '0;
            2: return 19'h55555;
            3: return 19'h2AAAA;
            default: return 19'(32'h1C3A5 + a * 32'h0F1D);
        endcase
    endfunction

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        logic [21:0] w;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (3) @(posedge clk);
        // R1 reset state
        check_all("R1 reset");
        chk("R1 div_load", div_load, 0);

        // R2 R4..R11 sweep of every address with several payloads
        for (int a = 0; a < 8; a++) begin
            for (int k = 0; k < 5; k++) begin
                w = {payload(k, a), 3'(a)};
                send_word(w);
                strobe_cnt = 0;
                latch_pulse();
                model_load(w);
                check_all($sformatf("R2 R10 addr %0d pat %0d", a, k));
                chk("R11 strobe count", strobe_cnt, (exp_strobe(a) != 0) ? 1 : 0);
                if (exp_strobe(a) != 0)
                    chk("R11 strobe bit", strobe_last, exp_strobe(a));
            end
        end

        // R4 run bit set then cleared
        send_word({19'h00001, 3'd0}); latch_pulse(); model_load({19'h00001, 3'd0});
        check_all("R4 run on");
        send_word({19'h7FFFE, 3'd0}); latch_pulse(); model_load({19'h7FFFE, 3'd0});
        check_all("R4 run off");

        // R3 shifting without latch changes nothing
        send_word({19'h13579, 3'd1});
        check_all("R3 shift only");
        chk("R3 no strobe", div_load, 0);

        // R12 latch held high: later word not loaded until next rise
        send_word({19'h0F0F0, 3'd1});
        strobe_cnt = 0;
        ser_latch = 1'b1;
        repeat (8) @(posedge clk);
        model_load({19'h0F0F0, 3'd1});
        check_all("R12 first load");
        send_word({19'h01234, 3'd1});
        check_all("R12 held high");
        chk("R12 one strobe", strobe_cnt, 1);
        ser_latch = 1'b0;
        repeat (6) @(posedge clk);
        latch_pulse();
        model_load({19'h01234, 3'd1});
        check_all("R12 next rise");

        done = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule